// File: doc/BRIEF.md
# Paged Write Cache with Timed Flush

This block buffers the data bytes of a single write command in a small cache of 8 lines of 8 bytes each. It sits between the serial slave's write port and the nonvolatile array. When a command starts, the low three address bits choose the byte within cache line 0 where loading begins. The upper address bits choose the array page that line 0 will be programmed into. Each later byte goes into the next cache position. After the last position the pointer wraps to line 0, byte 0, and later bytes overwrite earlier ones.

When the bus reports STOP, the controller walks the cache lines in order. For each line that holds at least one loaded byte it issues one page-program request. The request carries the page number, the eight data bytes and a byte enable. The byte enable is the loaded-byte mask combined with the write mask that the protection logic returns for that page. After the array acknowledges a request, a program timer runs for a fixed number of clock cycles, whether or not the page was full. The `busy` output stays high for the whole flush, and no command is taken while it is high.

Top module: `wcache_ctrl`

## Requirements
- R1: Out of reset, `busy` and `pg_req` are low.
- R2: With `busy` low, a `cmd_start` pulse latches page `cmd_addr[12:3]` as the flush base. The first following `wr_valid` byte goes to line 0 at byte `cmd_addr[2:0]`. Each later byte goes to the next cache position (position = line*8 + byte). After position 63 the next byte goes to position 0 and overwrites what was stored there.
- R3: Each accepted `cmd_start` clears the loaded-byte mask, so bytes from an earlier command are never enabled again.
- R4: A STOP while no byte has been loaded ends the command with no request, and `busy` stays low.
- R5: On flush, cache line i is requested at page (base + i) modulo 1024. Lines go out in ascending order, one request per line that holds a loaded byte, and the flush ends at the first empty line or after line 7.
- R6: Once `pg_req` rises, it stays high with `pg_addr`, `pg_data` and `pg_be` unchanged until a cycle in which `pg_ack` is high.
- R7: After each acknowledged request, the controller stays busy without a request for exactly PROG_CYCLES+1 cycles, and then raises the next request or drops `busy`. This holds even for a partly loaded line.
- R8: While `busy` is high, `cmd_start`, `wr_valid` and `stop` have no effect.
- R9: `pg_be` bit b is high only if byte b of the requested line was loaded in this command and bit b of `prot_mask` is high. The protection unit drives `prot_mask` from the `pg_addr` it is given.
- R10: A STOP after at least one loaded byte raises `busy` in the next cycle, and `busy` stays high until the last program time has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | A write command begins, with its address on `cmd_addr` |
| cmd_addr | input | 13 | Start address of the command: page in [12:3], byte in [2:0] |
| wr_valid | input | 1 | A data byte is present on `wr_data` |
| wr_data | input | 8 | Data byte to load |
| stop | input | 1 | STOP seen on the bus; starts the flush |
| prot_mask | input | 8 | Per-byte write permission for the page on `pg_addr` |
| pg_ack | input | 1 | The array accepts the current page request |
| busy | output | 1 | A flush is in progress |
| pg_req | output | 1 | Page program request |
| pg_addr | output | 10 | Array page to program |
| pg_data | output | 64 | Line data, byte b in bits [8b+7:8b] |
| pg_be | output | 8 | Byte enables for the page |

## Verification
The bench loads 66 bytes starting at byte 2 of a page near a 64-page block boundary. If the design did not wrap the pointer, or treated the overwritten positions wrongly, line 0 would show stale bytes, or the flush would stop early instead of emitting eight consecutive pages. A fill that starts near the top page checks that page numbers wrap modulo 1024 rather than saturating. A short command that follows a longer one must enable only its own byte, so a loaded-byte mask that was not cleared shows up as stray enable bits. The bench also holds off the acknowledge and injects command traffic during a flush. A controller that dropped or changed the request early, charged a shorter program time for a partial page, or accepted bytes while busy would produce wrong gap counts or extra requests.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SCAN,
    ST_REQ,
    ST_PROG
  } wc_state_e;
endpackage

// File: rtl/wc_store.sv
module wc_store #(
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = $clog2(LINES),
  localparam int PTR_W  = OFF_W + LINE_W,
  localparam int TOTAL  = LINES * LINE_BYTES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [OFF_W-1:0]        start_off,
  input  logic                    wr_en,
  input  logic [7:0]              wr_data,
  input  logic [LINE_W-1:0]       rd_line,
  output logic [LINE_BYTES*8-1:0] rd_data,
  output logic [LINE_BYTES-1:0]   rd_vld,
  output logic                    any_loaded,
  output logic [TOTAL-1:0]        vld_all
);

  logic [PTR_W-1:0] ptr_q;
  logic [TOTAL-1:0] vld_q;
  logic [7:0]       mem [TOTAL];
  logic [PTR_W-1:0] line_base;

  // Pointer advance; the cache size is a power of two, so the carry out wraps to 0.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] first_pos(input logic [OFF_W-1:0] off);
    return {{LINE_W{1'b0}}, off};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      vld_q <= '0;
    end else if (start) begin
      ptr_q <= first_pos(start_off);
      vld_q <= '0;
    end else if (wr_en) begin
      ptr_q        <= ptr_step(ptr_q);
      vld_q[ptr_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[ptr_q] <= wr_data;
  end

  assign line_base = {rd_line, {OFF_W{1'b0}}};

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_rd
    assign rd_data[b*8 +: 8] = mem[line_base + PTR_W'(b)];
    assign rd_vld[b]         = vld_q[line_base + PTR_W'(b)];
  end

  assign any_loaded = |vld_q;
  assign vld_all    = vld_q;

  // Between command starts, loaded bits are only ever added.
  assert_mask_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((vld_q & $past(vld_q)) == $past(vld_q)));

endmodule

// File: rtl/wc_prog_timer.sv
module wc_prog_timer #(
  parameter int CYCLES = 250000,
  localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);

  logic             running_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic at_limit(input logic [CNT_W-1:0] c);
    return c == CNT_W'(CYCLES - 1);
  endfunction

  assign done = running_q && at_limit(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (start) begin
      running_q <= 1'b1;
      cnt_q     <= '0;
    end else if (done) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (running_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // A new page program is never launched while one is still timing.
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running_q);

endmodule

// File: rtl/wc_seq.sv
module wc_seq
  import wc_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int PAGE_W = 10,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              wr_valid,
  input  logic              stop,
  input  logic              any_loaded,
  input  logic              line_has_data,
  input  logic              tmr_done,
  input  logic              pg_ack,
  output logic              busy,
  output logic              pg_req,
  output logic [PAGE_W-1:0] pg_addr,
  output logic [LINE_W-1:0] rd_line,
  output logic              store_start,
  output logic              store_wr,
  output logic              tmr_start
);

  wc_state_e         state_q, state_d;
  logic [LINE_W:0]   line_q;
  logic [PAGE_W-1:0] base_q;

  logic accept_cmd, flush_go, load_end_empty, scan_end, scan_req, line_done;

  function automatic logic [PAGE_W-1:0] page_of(input logic [PAGE_W-1:0] base,
                                                input logic [LINE_W:0]   line);
    return base + PAGE_W'(line);
  endfunction

  function automatic logic past_last(input logic [LINE_W:0] line);
    return line == (LINE_W+1)'(LINES);
  endfunction

  assign accept_cmd     = (state_q == ST_IDLE) && cmd_start;
  assign store_start    = accept_cmd;
  assign store_wr       = (state_q == ST_LOAD) && wr_valid;
  assign flush_go       = (state_q == ST_LOAD) && stop && (any_loaded || wr_valid);
  assign load_end_empty = (state_q == ST_LOAD) && stop && !(any_loaded || wr_valid);
  assign scan_end       = (state_q == ST_SCAN) && (past_last(line_q) || !line_has_data);
  assign scan_req       = (state_q == ST_SCAN) && !scan_end;
  assign tmr_start      = (state_q == ST_REQ) && pg_ack;
  assign line_done      = (state_q == ST_PROG) && tmr_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_cmd)     state_d = ST_LOAD;
      ST_LOAD: if (flush_go)       state_d = ST_SCAN;
               else if (load_end_empty) state_d = ST_IDLE;
      ST_SCAN: if (scan_end)       state_d = ST_IDLE;
               else                state_d = ST_REQ;
      ST_REQ:  if (tmr_start)      state_d = ST_PROG;
      ST_PROG: if (line_done)      state_d = ST_SCAN;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept_cmd) base_q <= cmd_page;
      if (flush_go)       line_q <= '0;
      else if (line_done) line_q <= line_q + (LINE_W+1)'(1);
    end
  end

  assign rd_line = line_q[LINE_W-1:0];
  assign busy    = (state_q == ST_SCAN) || (state_q == ST_REQ) || (state_q == ST_PROG);
  assign pg_req  = (state_q == ST_REQ);
  assign pg_addr = page_of(base_q, line_q);

  // Checker state: last acknowledged page of the current flush.
  logic              chk_prev_ok;
  logic [PAGE_W-1:0] chk_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_prev_ok <= 1'b0;
      chk_prev    <= '0;
    end else if (state_q == ST_LOAD) begin
      chk_prev_ok <= 1'b0;
    end else if (pg_req && pg_ack) begin
      chk_prev_ok <= 1'b1;
      chk_prev    <= pg_addr;
    end
  end

  // Each later page of a flush follows the previous one.
  assert_page_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pg_req) && chk_prev_ok) |-> (pg_addr == chk_prev + PAGE_W'(1)));

  // A request is never raised outside a flush.
  assert_req_in_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_req) |-> $past(busy));

endmodule

// File: rtl/wcache_ctrl.sv
module wcache_ctrl #(
  parameter int LINES       = 8,
  parameter int LINE_BYTES  = 8,
  parameter int ADDR_W      = 13,
  parameter int PROG_CYCLES = 250000,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = $clog2(LINES),
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int TOTAL  = LINES * LINE_BYTES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_start,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic                    wr_valid,
  input  logic [7:0]              wr_data,
  input  logic                    stop,
  input  logic [LINE_BYTES-1:0]   prot_mask,
  input  logic                    pg_ack,
  output logic                    busy,
  output logic                    pg_req,
  output logic [PAGE_W-1:0]       pg_addr,
  output logic [LINE_BYTES*8-1:0] pg_data,
  output logic [LINE_BYTES-1:0]   pg_be
);

  logic                  store_start, store_wr, any_loaded, tmr_start, tmr_done;
  logic [LINE_W-1:0]     rd_line;
  logic [LINE_BYTES-1:0] rd_vld;
  logic [TOTAL-1:0]      vld_all;

  wc_store #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (store_start),
    .start_off  (cmd_addr[OFF_W-1:0]),
    .wr_en      (store_wr),
    .wr_data    (wr_data),
    .rd_line    (rd_line),
    .rd_data    (pg_data),
    .rd_vld     (rd_vld),
    .any_loaded (any_loaded),
    .vld_all    (vld_all)
  );

  wc_seq #(.LINES(LINES), .PAGE_W(PAGE_W)) i_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_start     (cmd_start),
    .cmd_page      (cmd_addr[ADDR_W-1:OFF_W]),
    .wr_valid      (wr_valid),
    .stop          (stop),
    .any_loaded    (any_loaded),
    .line_has_data (|rd_vld),
    .tmr_done      (tmr_done),
    .pg_ack        (pg_ack),
    .busy          (busy),
    .pg_req        (pg_req),
    .pg_addr       (pg_addr),
    .rd_line       (rd_line),
    .store_start   (store_start),
    .store_wr      (store_wr),
    .tmr_start     (tmr_start)
  );

  wc_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .done  (tmr_done)
  );

  assign pg_be = rd_vld & prot_mask;

  // The request and its payload hold until acknowledged.
  assert_req_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_req && !pg_ack) |=> (pg_req && $stable(pg_addr) && $stable(pg_data) && $stable(pg_be)));

  // Nothing loads or clears the cache while a flush runs.
  assert_busy_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(vld_all));

  // Reset leaves the block quiet.
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!busy && !pg_req));

endmodule

// File: tb/test_wcache_ctrl.sv
module test_wcache_ctrl;
  localparam int PROG = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [12:0] cmd_addr = '0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        stop = 1'b0;
  logic [7:0]  prot_mask;
  logic        pg_ack = 1'b0;
  logic        busy, pg_req;
  logic [9:0]  pg_addr;
  logic [63:0] pg_data;
  logic [7:0]  pg_be;

  int checks = 0;
  int errors = 0;

  int       prot_page = -1;
  bit [7:0] prot_pat  = 8'hFF;
  bit [7:0] mdat [64];
  bit       mval [64];
  int       mbase;

  always #10 clk = ~clk;

  function automatic bit [7:0] bprot(input int page);
    return (page == prot_page) ? prot_pat : 8'hFF;
  endfunction

  always_comb prot_mask = bprot(int'(pg_addr));

  wcache_ctrl #(.PROG_CYCLES(PROG)) i_wcache_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .wr_valid(wr_valid), .wr_data(wr_data), .stop(stop), .prot_mask(prot_mask),
    .pg_ack(pg_ack), .busy(busy), .pg_req(pg_req), .pg_addr(pg_addr),
    .pg_data(pg_data), .pg_be(pg_be)
  );

  function automatic bit [7:0] dval(input int seed, input int k);
    return 8'(seed + k * 13);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cmd(input int addr, input int n, input int seed);
    @(negedge clk);
    cmd_start = 1'b1; cmd_addr = 13'(addr);
    @(negedge clk);
    cmd_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      wr_valid = 1'b1; wr_data = dval(seed, k);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    for (int p = 0; p < 64; p++) mval[p] = 1'b0;
    for (int k = 0; k < n; k++) begin
      int p;
      p = ((addr % 8) + k) % 64;
      mdat[p] = dval(seed, k);
      mval[p] = 1'b1;
    end
    mbase = addr / 8;
  endtask

  function automatic int exp_lines();
    int n = 0;
    for (int l = 0; l < 8; l++) begin
      bit any = 1'b0;
      for (int b = 0; b < 8; b++) any |= mval[l*8+b];
      if (!any) break;
      n++;
    end
    return n;
  endfunction

  // Runs one flush, checking every request, the hold-off and the program gap.
  task automatic check_flush(input int ack_delay);
    int nexp, r, wait_cnt;
    nexp = exp_lines();
    r = 0;
    wait_cnt = 0;
    chk(busy == 1'b1, "R10 busy after stop", busy, 1);
    while (r < 9 && wait_cnt < 200) begin
      if (pg_req) begin
        int ea, gap;
        bit [7:0] ebe;
        ea = (mbase + r) % 1024;
        ebe = '0;
        for (int b = 0; b < 8; b++) ebe[b] = mval[r*8+b] & bprot(ea)[b];
        chk(int'(pg_addr) == ea, "R5 page address", pg_addr, ea);
        chk(pg_be == ebe, "R9 byte enable", pg_be, ebe);
        for (int b = 0; b < 8; b++)
          if (ebe[b]) chk(pg_data[b*8 +: 8] == mdat[r*8+b], "R2 line data", pg_data[b*8 +: 8], mdat[r*8+b]);
        for (int d = 0; d < ack_delay; d++) begin
          @(negedge clk);
          chk(pg_req && int'(pg_addr) == ea && pg_be == ebe, "R6 request held", {pg_req, pg_addr}, {1'b1, 10'(ea)});
        end
        pg_ack = 1'b1;
        @(negedge clk);
        pg_ack = 1'b0;
        gap = 0;
        while (busy && !pg_req && gap < 1000) begin
          gap++;
          @(negedge clk);
        end
        chk(gap == PROG + 1, "R7 program gap", gap, PROG + 1);
        r++;
      end else if (!busy) begin
        break;
      end else begin
        wait_cnt++;
        @(negedge clk);
      end
    end
    chk(r == nexp, "R5 request count", r, nexp);
    chk(busy == 1'b0, "R10 busy ends", busy, 0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(pg_req == 1'b0, "R1 req in reset", pg_req, 0);
  endtask

  task automatic t_single();
    write_cmd(13'h0123, 1, 8'h40);
    check_flush(0);
  endtask

  task automatic t_aligned();
    write_cmd(5 * 8, 16, 8'h11);
    check_flush(1);
  endtask

  task automatic t_wrap_overwrite();
    write_cmd(62 * 8 + 2, 66, 8'h07);
    chk(mdat[2] == dval(8'h07, 64), "R2 overwrite model", mdat[2], dval(8'h07, 64));
    check_flush(3);
  endtask

  task automatic t_top_wrap();
    write_cmd(1020 * 8, 40, 8'h5A);
    check_flush(0);
  endtask

  task automatic t_mask_clear();
    write_cmd(9 * 8, 1, 8'hC3);
    check_flush(0);
  endtask

  task automatic t_empty_stop();
    write_cmd(20 * 8 + 4, 0, 0);
    for (int i = 0; i < 5; i++) begin
      chk(!busy && !pg_req, "R4 empty stop quiet", {busy, pg_req}, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_protect();
    prot_page = 41;
    prot_pat  = 8'h0F;
    write_cmd(40 * 8, 16, 8'h99);
    check_flush(0);
    prot_page = -1;
    prot_pat  = 8'hFF;
  endtask

  task automatic t_busy_ignore();
    write_cmd(12 * 8, 8, 8'h21);
    @(negedge clk);
    cmd_start = 1'b1; cmd_addr = 13'h0300;
    @(negedge clk);
    cmd_start = 1'b0; wr_valid = 1'b1; wr_data = 8'hEE;
    @(negedge clk);
    wr_valid = 1'b0; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check_flush(0);
    for (int i = 0; i < 10; i++) begin
      chk(!busy && !pg_req, "R8 traffic while busy ignored", {busy, pg_req}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_aligned();
    t_wrap_overwrite();
    t_top_wrap();
    t_mask_clear();
    t_empty_stop();
    t_protect();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule